// File: doc/BRIEF.md
# Six-Way Cache Tag Lookup and Replacement Unit

This block holds the tag side of a set-associative cache with six ways per set. An incoming address is split into a tag, a set index and a word offset. The six tag entries of the selected set are compared at the same time. The block then returns hit or miss and a way number one cycle later.

Each set keeps an exact recency ordering of its six way numbers. A miss can therefore name the way to replace. A separate fill port installs a tag once the line has been fetched elsewhere. Data storage, write-back and the memory side are outside the block.

The set count is derived from parameters as cache size in words divided by the product of words per block and six. The offset width is log2 of the words per block. The index width is log2 of the set count. The tag takes the remaining upper address bits.

Top module: `cache6_lookup`

## Requirements
- R1: The address is read as {tag, set index, word offset}, most significant first. The offset is the low log2(WORDS_PER_BLOCK) bits and the index is the next log2(set count) bits. Addresses that differ only in the offset give the same result.
- R2: When a valid way of the selected set holds the request tag, the response has resp_hit=1 and resp_way equal to that way number (0..5).
- R3: resp_hit=0 only when none of the six ways of the set holds a valid matching tag.
- R4: A lookup is accepted on a clock edge where req_valid and req_ready are both 1. resp_valid is 1 in exactly the cycle after each accepted lookup and 0 at all other times.
- R5: On a miss, and for a fill of an absent tag, the chosen way is the lowest-numbered invalid way of the set, if the set has one.
- R6: When all six ways are valid, the chosen way is the least recently used one. A fill of an absent tag evicts it, so a later lookup of the old tag misses.
- R7: A lookup hit, or any fill, makes the way it used the most recent way of its set. A lookup miss leaves the ordering unchanged.
- R8: A fill whose tag is already valid in the set writes no second copy. It reports the existing way and only refreshes its recency.
- R9: After reset every way is invalid, the ordering of each set is 0 (most recent) through 5 (least recent), and resp_valid and fill_done are 0.
- R10: req_ready is 0 whenever fill_valid is 1. A lookup offered in that cycle is not accepted and produces no response.
- R11: Each cycle with fill_valid=1 is followed by one cycle with fill_done=1 and fill_way naming the way now holding the fill tag, marked valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Lookup address |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_valid | output | 1 | Lookup response valid |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_way | output | 3 | Hit way, or the victim way on a miss |
| fill_valid | input | 1 | Install the tag of fill_addr |
| fill_addr | input | ADDR_W | Address whose line is installed |
| fill_done | output | 1 | Fill completed (one cycle after fill_valid) |
| fill_way | output | 3 | Way written or refreshed by the fill |

## Verification
The bench fills a set with seven distinct tags after reordering its recency through hits. It then confirms that the oldest line leaves. A design with a stale or tree-approximated ordering would evict a more recent way, and the old tag would still hit. Fills into sets that still have invalid ways check the lowest-invalid preference, where a wrong design would overwrite live lines. Refills of resident tags check that no duplicate copy appears, which would make a later hit report two ways. Lookups offered during a fill must produce no response, and a long mixed sequence with varied offsets is compared against an arithmetic model of the ordering.

// File: rtl/cache6_pkg.sv
package cache6_pkg;
  localparam int WAYS  = 6;
  localparam int WAY_W = 3;

  typedef logic [WAY_W-1:0] way_t;
  // slot 0 holds the most recent way, slot WAYS-1 the least recent
  typedef way_t [WAYS-1:0]  order_t;

  function automatic order_t order_init();
    order_t o;
    for (int i = 0; i < WAYS; i++) o[i] = way_t'(i);
    return o;
  endfunction

  // move way w to the front, shifting the younger entries back by one
  function automatic order_t order_touch(order_t o, way_t w);
    order_t n;
    logic   found;
    found = 1'b0;
    n     = o;
    n[0]  = w;
    for (int i = 1; i < WAYS; i++) begin
      if (o[i-1] == w) found = 1'b1;
      if (!found) n[i] = o[i-1];
    end
    return n;
  endfunction

  // lowest invalid way first, otherwise the tail of the ordering
  function automatic way_t pick_victim(logic [WAYS-1:0] vld, order_t o);
    way_t v;
    v = o[WAYS-1];
    for (int i = WAYS-1; i >= 0; i--) begin
      if (!vld[i]) v = way_t'(i);
    end
    return v;
  endfunction
endpackage

// File: rtl/cache6_tag_match.sv
module cache6_tag_match
  import cache6_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
  input  logic [WAYS-1:0]            set_valid,
  input  logic [TAG_W-1:0]           key_tag,
  output logic [WAYS-1:0]            match_vec,
  output logic                       any_hit,
  output way_t                       hit_way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = set_valid[g] && (set_tags[g] == key_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int i = WAYS-1; i >= 0; i--) begin
      if (match_vec[i]) hit_way = way_t'(i);
    end
  end

  assign any_hit = |match_vec;
endmodule

// File: rtl/cache6_recency.sv
module cache6_recency
  import cache6_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              touch_en,
  input  logic [IDX_W-1:0]  touch_set,
  input  way_t              touch_way,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WAYS-1:0]   rd_valid,
  output way_t              victim
);
  order_t order_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) order_q[s] <= order_init();
    end else if (touch_en) begin
      order_q[touch_set] <= order_touch(order_q[touch_set], touch_way);
    end
  end

  assign victim = pick_victim(rd_valid, order_q[rd_set]);

  // every set must always hold each way number exactly once
  logic perm_ok;
  always_comb begin
    perm_ok = 1'b1;
    for (int s = 0; s < SETS; s++) begin
      logic [7:0] seen;
      seen = '0;
      for (int i = 0; i < WAYS; i++) seen[order_q[s][i]] = 1'b1;
      if (seen != 8'h3F) perm_ok = 1'b0;
    end
  end

  p_order_permutation_r6: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ok);

  p_touch_becomes_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> order_q[$past(touch_set)][0] == $past(touch_way));

  p_victim_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    victim < way_t'(WAYS));
endmodule

// File: rtl/cache6_lookup.sv
module cache6_lookup
  import cache6_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int WORDS_PER_BLOCK = 4,
  parameter int CACHE_WORDS     = 1536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [2:0]        resp_way,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  output logic              fill_done,
  output logic [2:0]        fill_way
);
  localparam int OFF_W = $clog2(WORDS_PER_BLOCK);
  localparam int SETS  = CACHE_WORDS / (WORDS_PER_BLOCK * WAYS);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] set_of(logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];

  // named internal events
  logic              lk_fire;
  logic [ADDR_W-1:0] sel_addr;
  logic [TAG_W-1:0]  sel_tag;
  logic [IDX_W-1:0]  sel_set;
  logic [WAYS-1:0]   match_vec;
  logic              sel_hit;
  way_t              hit_way, victim, pick_way;
  logic              touch_en;

  assign req_ready = !fill_valid;
  assign lk_fire   = req_valid && req_ready;
  assign sel_addr  = fill_valid ? fill_addr : req_addr;
  assign sel_tag   = tag_of(sel_addr);
  assign sel_set   = set_of(sel_addr);

  cache6_tag_match #(.TAG_W(TAG_W)) u_match (
    .set_tags  (tag_q[sel_set]),
    .set_valid (valid_q[sel_set]),
    .key_tag   (sel_tag),
    .match_vec (match_vec),
    .any_hit   (sel_hit),
    .hit_way   (hit_way)
  );

  assign pick_way = sel_hit ? hit_way : victim;
  assign touch_en = fill_valid || (lk_fire && sel_hit);

  cache6_recency #(.SETS(SETS), .IDX_W(IDX_W)) u_rec (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_set (sel_set),
    .touch_way (pick_way),
    .rd_set    (sel_set),
    .rd_valid  (valid_q[sel_set]),
    .victim    (victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_way   <= '0;
      fill_done  <= 1'b0;
      fill_way   <= '0;
    end else begin
      resp_valid <= lk_fire;
      fill_done  <= fill_valid;
      if (lk_fire) begin
        resp_hit <= sel_hit;
        resp_way <= pick_way;
      end
      if (fill_valid) begin
        fill_way <= pick_way;
        if (!sel_hit) valid_q[sel_set][pick_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !sel_hit) tag_q[sel_set][pick_way] <= sel_tag;
  end

  p_resp_follows_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> resp_valid);
  p_no_stray_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_fire |=> !resp_valid);
  p_fill_blocks_lookup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);
  p_fill_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (fill_done && fill_way < 3'd6));
  p_fill_leaves_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> valid_q[$past(sel_set)][fill_way]);
  p_no_duplicate_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
  p_resp_way_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_way < 3'd6);
endmodule

// File: tb/sim_cache6_lookup.sv
module sim_cache6_lookup;
  localparam int AW = 12;
  localparam int NS = 4;   // 96 words / (4 words * 6 ways)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, fill_addr = '0;
  logic req_ready, resp_valid, resp_hit, fill_done;
  logic [2:0] resp_way, fill_way;

  always #2 clk = ~clk;  // 250 MHz

  cache6_lookup #(.ADDR_W(AW), .WORDS_PER_BLOCK(4), .CACHE_WORDS(96)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_done(fill_done), .fill_way(fill_way));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural model
  int mtag [NS][6];
  bit mval [NS][6];
  int mord [NS][6];

  function automatic int mk_addr(int t, int s, int off);
    return t * 16 + s * 4 + off;
  endfunction

  function automatic int m_find(int s, int t);
    for (int w = 0; w < 6; w++) if (mval[s][w] && mtag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_victim(int s);
    for (int w = 0; w < 6; w++) if (!mval[s][w]) return w;
    return mord[s][5];
  endfunction

  task automatic m_touch(int s, int w);
    int p;
    p = 0;
    for (int i = 0; i < 6; i++) if (mord[s][i] == w) p = i;
    for (int i = p; i > 0; i--) mord[s][i] = mord[s][i-1];
    mord[s][0] = w;
  endtask

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic lookup(int t, int s, int off, string rq);
    int ew;
    bit eh;
    ew = m_find(s, t);
    eh = (ew >= 0);
    if (!eh) ew = m_victim(s);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(mk_addr(t, s, off));
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid == 1'b1, "R4", "resp_valid", int'(resp_valid), 1);
    chk(resp_hit == eh, rq, "resp_hit", int'(resp_hit), int'(eh));
    chk(int'(resp_way) == ew, rq, "resp_way", int'(resp_way), ew);
    if (eh) m_touch(s, ew);
  endtask

  task automatic fill(int t, int s, bit also_req, string rq);
    int ew;
    ew = m_find(s, t);
    if (ew < 0) ew = m_victim(s);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_addr  = AW'(mk_addr(t, s, 3));
    req_valid  = also_req;
    req_addr   = AW'(mk_addr(t, s, 0));
    #0.5;
    chk(req_ready == 1'b0, "R10", "req_ready during fill", int'(req_ready), 0);
    @(negedge clk);
    fill_valid = 1'b0;
    req_valid  = 1'b0;
    chk(fill_done == 1'b1, "R11", "fill_done", int'(fill_done), 1);
    chk(int'(fill_way) == ew, rq, "fill_way", int'(fill_way), ew);
    if (also_req)
      chk(resp_valid == 1'b0, "R10", "resp during fill", int'(resp_valid), 0);
    mtag[s][ew] = t;
    mval[s][ew] = 1'b1;
    m_touch(s, ew);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int seed;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < 6; w++) begin
        mval[s][w] = 0; mtag[s][w] = 0; mord[s][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(resp_valid == 1'b0, "R9", "resp_valid", int'(resp_valid), 0);
    chk(fill_done == 1'b0, "R9", "fill_done", int'(fill_done), 0);
    chk(req_ready == 1'b1, "R9", "req_ready", int'(req_ready), 1);
    // empty cache: miss names way 0 (R3, R5)
    lookup(5, 2, 1, "R3");
    @(negedge clk);
    chk(resp_valid == 1'b0, "R4", "resp_valid idle", int'(resp_valid), 0);

    // R5: fills into empty sets take ways 0..5 in order
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 6; k++) begin
        fill(20 + k + 8 * s, s, 1'b0, "R5");
        chk(int'(fill_way) == k, "R5", "lowest invalid way", int'(fill_way), k);
      end

    // R1/R2: every resident tag hits, for every offset
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 6; k++)
        lookup(20 + k + 8 * s, s, (k + s) % 4, "R1");

    // R7/R6: reorder set 1, then a seventh tag evicts the oldest
    lookup(20 + 3 + 8, 1, 0, "R7");
    lookup(20 + 0 + 8, 1, 1, "R7");
    lookup(20 + 5 + 8, 1, 2, "R7");
    lookup(20 + 1 + 8, 1, 3, "R7");
    lookup(20 + 4 + 8, 1, 0, "R7");
    lookup(20 + 2 + 8, 1, 1, "R7");
    lookup(99, 1, 0, "R7");             // miss: ordering unchanged, victim way 3
    chk(int'(resp_way) == 3, "R6", "victim after reorder", int'(resp_way), 3);
    fill(99, 1, 1'b1, "R6");
    chk(int'(fill_way) == 3, "R6", "evicted way", int'(fill_way), 3);
    lookup(20 + 3 + 8, 1, 2, "R6");     // evicted tag now misses
    chk(resp_hit == 1'b0, "R6", "old tag gone", int'(resp_hit), 0);
    lookup(99, 1, 3, "R2");

    // R8: refilling a resident tag reuses its way
    fill(20 + 4 + 16, 2, 1'b0, "R8");
    chk(int'(fill_way) == 4, "R8", "existing way", int'(fill_way), 4);
    lookup(20 + 4 + 16, 2, 0, "R8");

    // mixed sweep against the model
    seed = 7;
    for (int i = 0; i < 400; i++) begin
      int t, s, op;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      t  = 40 + ((seed >> 4) % 8);
      s  = (seed >> 8) % NS;
      op = (seed >> 12) % 3;
      if (op == 0) fill(t, s, (seed >> 16) & 1, "R6");
      else lookup(t, s, (seed >> 18) % 4, "R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule